// File: doc/BRIEF.md
# Flash Command Controller with Ready/Busy

This block is the control logic of a parallel NOR flash device, written as a synthesizable model. It watches a synchronously sampled active-low write-enable input. A write cycle counts as complete on the rising edge of write-enable. The block then matches the address and the low data byte of each completed write against the expected step of an unlock-and-command sequence. A program sequence has four steps and an erase sequence has six. When the final step of a valid sequence lands, the block starts a simulated embedded operation. That operation lasts a fixed number of clock cycles, and while it runs the block holds its ready/busy line low.

Ready/busy is modelled as a pull-low enable. When `rb_pull_low` is 1 the pin is driven to 0. When it is 0 the pin is released, so several devices can share one pulled-up line. During a running erase, a suspend command releases the line and freezes the remaining time, and a resume command continues the erase. A low-supply lockout flag and an abort request both cancel any operation and return the controller to read mode.

The FSM states are these:
- `ST_READ` is idle.
- `ST_UNL1` and `ST_UNL2` hold the two unlock writes.
- `ST_PGM_ARM` waits for the program address and data.
- `ST_ERS_ARM`, `ST_ERS_UNL1` and `ST_ERS_UNL2` hold the erase set-up and the second unlock pair.
- `ST_PGM_BUSY`, `ST_ERS_BUSY` and `ST_ERS_SUSP` are the operation states.

The FSM transitions are these:
- An unlock match advances one state.
- Any mismatch goes to `ST_READ`.
- A final step goes to a busy state.
- Expiry of the timer goes back to `ST_READ`.
- The suspend code takes `ST_ERS_BUSY` to `ST_ERS_SUSP`, and the resume code takes it back.
- Lockout or abort goes to `ST_READ` from any state.

Top module: `nfc_ctrl`

## Requirements
- R1: After reset, the mode is read (`mode`=0), `rb_pull_low`=0 and `op_start`=0.
- R2: The program sequence is four writes: (KEY_ADDR_A, 0xAA), (KEY_ADDR_B, 0x55), (KEY_ADDR_A, 0xA0), then any address and data. Busy starts only after the rising write-enable edge of the 4th write, with `mode`=1.
- R3: The erase sequence is six writes: (A, 0xAA), (B, 0x55), (A, 0x80), (A, 0xAA), (B, 0x55), then either (A, 0x10) or (any address, 0x30). Busy starts only after the 6th write, with `mode`=2.
- R4: Busy lasts exactly PGM_CYCLES clock cycles for a program and ERS_CYCLES for an erase. After that, `rb_pull_low` returns to 0 and `mode` returns to 0.
- R5: While a program or erase runs, every write is ignored. A complete sequence written during busy starts nothing, and it leaves no partial progress behind.
- R6: During an erase, a write of 0xB0 enters suspend (`mode`=3) and releases ready/busy. The remaining time stays frozen until a write of 0x30 resumes the erase. The total busy time is still ERS_CYCLES.
- R7: Only data bits 7..0 are decoded. The upper data bits have no effect on any command step.
- R8: A write whose address or data does not match the expected step returns the controller to read mode without starting anything. The next sequence must begin again from its first step.
- R9: While `lockout`=1, the controller is in read mode one cycle later and `rb_pull_low`=0. Any operation is abandoned, and all writes, including partial sequences, are ignored.
- R10: While `abort_req`=1, `rb_pull_low`=1 immediately. The controller goes to read mode one cycle later and writes are ignored. Once the request is released, the line is freed.
- R11: `op_start` pulses for one cycle when an operation starts. The pulse is in the same cycle busy first shows. `op_erase` is 1 for an erase and 0 for a program.
- R12: The `mode` encoding is 0 for read, 1 for program busy, 2 for erase busy and 3 for erase suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| we_n | input | 1 | Active-low write enable, sampled on clk |
| addr | input | AW | Write address |
| din | input | DW | Write data; only bits 7..0 are decoded |
| lockout | input | 1 | Low-supply lockout flag |
| abort_req | input | 1 | Reset-abort request |
| rb_pull_low | output | 1 | 1 drives the shared ready/busy line low |
| mode | output | 2 | Controller mode (R12 encoding) |
| op_start | output | 1 | One-cycle pulse at operation start |
| op_erase | output | 1 | Kind of the last started operation |

## Verification
The bench counts cycles to the exact edge at which busy must appear and disappear. An off-by-one in the busy timer, or busy raised on the penultimate write, therefore shows up as a wrong level at a single sample. It also writes whole command sequences while a program is busy, and then sends a single data write afterwards. A design that kept decoding during busy would start a second operation or leave a half-armed sequence behind. For suspend and resume it checks that the total busy time still equals the erase length. A counter that kept running, or one that reloaded on resume, would finish early or late. It also interleaves lockout with a partial sequence. A design that kept its sequence position across lockout would start a program from the last two writes.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_ERS_SUSP
    } ctl_state_t;

    localparam logic [1:0] MODE_READ = 2'd0;
    localparam logic [1:0] MODE_PGM  = 2'd1;
    localparam logic [1:0] MODE_ERS  = 2'd2;
    localparam logic [1:0] MODE_SUSP = 2'd3;

endpackage

// File: rtl/nfc_we_edge.sv
module nfc_we_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic wr_stb
);

    logic we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    // a write completes when write-enable returns high
    assign wr_stb = we_n & ~we_q;

    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/nfc_op_timer.sv
module nfc_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expire
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (clear)                  cnt <= '0;
        else if (load)                   cnt <= load_val;
        else if (run && cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign expire = run && !load && (cnt == CW'(1));

    p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |-> (cnt != '0));

endmodule

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
    import nfc_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          CW         = 8,
    parameter int          PGM_CYCLES = 20,
    parameter int          ERS_CYCLES = 40,
    parameter logic [AW-1:0] KEY_ADDR_A = 16'h0555,
    parameter logic [AW-1:0] KEY_ADDR_B = 16'h02AA,
    parameter logic [7:0]  KEY_1      = 8'hAA,
    parameter logic [7:0]  KEY_2      = 8'h55,
    parameter logic [7:0]  C_PGM      = 8'hA0,
    parameter logic [7:0]  C_ERS      = 8'h80,
    parameter logic [7:0]  C_CHIP     = 8'h10,
    parameter logic [7:0]  C_SECT     = 8'h30,
    parameter logic [7:0]  C_SUSP     = 8'hB0,
    parameter logic [7:0]  C_RES      = 8'h30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    cmd,
    input  logic          lockout,
    input  logic          abort_req,
    input  logic          expire,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_run,
    output logic          tmr_clear,
    output logic [1:0]    mode_o,
    output logic          busy_o,
    output logic          op_start,
    output logic          op_erase
);

    ctl_state_t state, nxt;
    logic start_pgm, start_ers;
    logic hit_k1, hit_k2;

    assign hit_k1 = (addr == KEY_ADDR_A) && (cmd == KEY_1);
    assign hit_k2 = (addr == KEY_ADDR_B) && (cmd == KEY_2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt       = state;
        start_pgm = 1'b0;
        start_ers = 1'b0;
        if (lockout || abort_req) begin
            nxt = ST_READ;
        end else begin
            unique case (state)
                ST_READ:     if (wr_stb && hit_k1) nxt = ST_UNL1;
                ST_UNL1:     if (wr_stb) nxt = hit_k2 ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    if (wr_stb) begin
                        if (addr == KEY_ADDR_A && cmd == C_PGM)      nxt = ST_PGM_ARM;
                        else if (addr == KEY_ADDR_A && cmd == C_ERS) nxt = ST_ERS_ARM;
                        else                                         nxt = ST_READ;
                    end
                end
                ST_PGM_ARM: begin
                    if (wr_stb) begin
                        nxt       = ST_PGM_BUSY;
                        start_pgm = 1'b1;
                    end
                end
                ST_ERS_ARM:  if (wr_stb) nxt = hit_k1 ? ST_ERS_UNL1 : ST_READ;
                ST_ERS_UNL1: if (wr_stb) nxt = hit_k2 ? ST_ERS_UNL2 : ST_READ;
                ST_ERS_UNL2: begin
                    if (wr_stb) begin
                        if ((addr == KEY_ADDR_A && cmd == C_CHIP) || cmd == C_SECT) begin
                            nxt       = ST_ERS_BUSY;
                            start_ers = 1'b1;
                        end else begin
                            nxt = ST_READ;
                        end
                    end
                end
                ST_PGM_BUSY: if (expire) nxt = ST_READ;
                ST_ERS_BUSY: begin
                    if (expire)                         nxt = ST_READ;
                    else if (wr_stb && cmd == C_SUSP)   nxt = ST_ERS_SUSP;
                end
                ST_ERS_SUSP: if (wr_stb && cmd == C_RES) nxt = ST_ERS_BUSY;
                default:     nxt = ST_READ;
            endcase
        end
    end

    // timer control
    assign tmr_load  = start_pgm | start_ers;
    assign tmr_val   = start_ers ? CW'(ERS_CYCLES) : CW'(PGM_CYCLES);
    assign tmr_run   = (state == ST_PGM_BUSY) || (state == ST_ERS_BUSY);
    assign tmr_clear = lockout | abort_req;

    // outputs
    always_comb begin
        unique case (state)
            ST_PGM_BUSY: begin mode_o = MODE_PGM;  busy_o = 1'b1; end
            ST_ERS_BUSY: begin mode_o = MODE_ERS;  busy_o = 1'b1; end
            ST_ERS_SUSP: begin mode_o = MODE_SUSP; busy_o = 1'b0; end
            default:     begin mode_o = MODE_READ; busy_o = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_erase <= 1'b0;
        end else begin
            op_start <= start_pgm | start_ers;
            if (start_pgm | start_ers) op_erase <= start_ers;
        end
    end

    p_start_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(mode_o) == MODE_READ));
    p_lockout_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (mode_o == MODE_READ));
    p_abort_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (mode_o == MODE_READ));
    p_susp_from_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MODE_SUSP) && !$stable(mode_o)) |-> ($past(mode_o) == MODE_ERS));

endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
    import nfc_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter int          PGM_CYCLES = 20,
    parameter int          ERS_CYCLES = 40,
    parameter logic [AW-1:0] KEY_ADDR_A = 16'h0555,
    parameter logic [AW-1:0] KEY_ADDR_B = 16'h02AA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          lockout,
    input  logic          abort_req,
    output logic          rb_pull_low,
    output logic [1:0]    mode,
    output logic          op_start,
    output logic          op_erase
);

    localparam int MAXC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic          wr_stb, expire, tmr_load, tmr_run, tmr_clear, busy;
    logic [CW-1:0] tmr_val;

    nfc_we_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_n   (we_n),
        .wr_stb (wr_stb)
    );

    nfc_cmd_fsm #(
        .AW         (AW),
        .CW         (CW),
        .PGM_CYCLES (PGM_CYCLES),
        .ERS_CYCLES (ERS_CYCLES),
        .KEY_ADDR_A (KEY_ADDR_A),
        .KEY_ADDR_B (KEY_ADDR_B)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .addr      (addr),
        .cmd       (din[7:0]),
        .lockout   (lockout),
        .abort_req (abort_req),
        .expire    (expire),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_run   (tmr_run),
        .tmr_clear (tmr_clear),
        .mode_o    (mode),
        .busy_o    (busy),
        .op_start  (op_start),
        .op_erase  (op_erase)
    );

    nfc_op_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .expire   (expire)
    );

    // busy is shown while an operation runs and for the whole abort pulse
    assign rb_pull_low = busy | abort_req;

    p_busy_pulls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PGM) || (mode == MODE_ERS)) |-> rb_pull_low);
    p_susp_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SUSP) && !abort_req) |-> !rb_pull_low);
    p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (rb_pull_low || abort_req));

endmodule

// File: tb/nfc_ctrl_test.sv
module nfc_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int PGM_C = 20;
    localparam int ERS_C = 40;
    localparam logic [15:0] KA = 16'h0555;
    localparam logic [15:0] KB = 16'h02AA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] din = '0;
    logic lockout = 1'b0;
    logic abort_req = 1'b0;
    logic rb_pull_low, op_start, op_erase;
    logic [1:0] mode;
    logic rb_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // pulled-up shared line
    assign rb_line = rb_pull_low ? 1'b0 : 1'b1;

    nfc_ctrl #(.PGM_CYCLES(PGM_C), .ERS_CYCLES(ERS_C)) uut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .din(din),
        .lockout(lockout), .abort_req(abort_req), .rb_pull_low(rb_pull_low),
        .mode(mode), .op_start(op_start), .op_erase(op_erase)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); we_n = 1'b0; addr = a; din = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 200 && mode != 2'd0; i++) @(negedge clk);
    endtask

    // {addr, data, expected mode, settle-after}
    localparam int NV = 17;
    localparam logic [34:0] VEC [NV] = '{
        {16'h0555, 16'h12AA, 2'd0, 1'b0},   // R7 upper bits ignored
        {16'h02AA, 16'hFF55, 2'd0, 1'b0},
        {16'h0555, 16'h00A0, 2'd0, 1'b0},
        {16'h1234, 16'hBEEF, 2'd1, 1'b1},   // R2 program busy
        {16'h0555, 16'h00AA, 2'd0, 1'b0},
        {16'h0123, 16'h0055, 2'd0, 1'b0},   // R8 wrong address
        {16'h0555, 16'h00A0, 2'd0, 1'b0},   // R8 not a valid first step
        {16'h0555, 16'h00AA, 2'd0, 1'b0},
        {16'h02AA, 16'h0055, 2'd0, 1'b0},
        {16'h0555, 16'h0080, 2'd0, 1'b0},
        {16'h0555, 16'h00AA, 2'd0, 1'b0},
        {16'h02AA, 16'h0055, 2'd0, 1'b0},
        {16'h7777, 16'h0030, 2'd2, 1'b1},   // R3 sector erase
        {16'h0555, 16'h00AA, 2'd0, 1'b0},
        {16'h02AA, 16'h0055, 2'd0, 1'b0},
        {16'h0555, 16'h0077, 2'd0, 1'b0},   // R8 wrong command
        {16'h0000, 16'h0000, 2'd0, 1'b0}    // R8 nothing armed
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode, 2'd0);
        chk("R1 line", rb_line, 1'b1);
        chk("R1 op_start", op_start, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R7 R8 R12
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][34:19], VEC[i][18:3]);
            chk($sformatf("R12 vector %0d mode", i), mode, VEC[i][2:1]);
            if (VEC[i][0]) settle();
        end

        // R2 R4 R11 program timing
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0);
        chk("R2 not busy before 4th", rb_line, 1'b1);
        wr(16'h0040, 16'h1111);
        chk("R2 busy after 4th", rb_line, 1'b0);
        chk("R11 op_start", op_start, 1'b1);
        chk("R11 op_erase prog", op_erase, 1'b0);
        @(negedge clk);
        chk("R11 op_start one cycle", op_start, 1'b0);
        repeat (PGM_C - 2) @(negedge clk);
        chk("R4 program still busy", rb_line, 1'b0);
        @(negedge clk);
        chk("R4 program ready", rb_line, 1'b1);
        chk("R4 program mode read", mode, 2'd0);

        // R3 R4 chip erase timing
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0080);
        wr(KA, 16'h00AA); wr(KB, 16'h0055);
        chk("R3 not busy before 6th", rb_line, 1'b1);
        wr(KA, 16'h0010);
        chk("R3 chip erase mode", mode, 2'd2);
        chk("R11 op_erase", op_erase, 1'b1);
        repeat (ERS_C - 1) @(negedge clk);
        chk("R4 erase still busy", rb_line, 1'b0);
        @(negedge clk);
        chk("R4 erase ready", rb_line, 1'b1);

        // R5 rejection during program busy
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(16'h0002, 16'h2222);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(16'h0003, 16'h3333);
        chk("R5 still busy, no restart", rb_line, 1'b0);
        chk("R5 no op_start", op_start, 1'b0);
        repeat (7) @(negedge clk);
        chk("R5 busy unchanged length", rb_line, 1'b0);
        @(negedge clk);
        chk("R5 ready on time", rb_line, 1'b1);
        wr(16'h0004, 16'h4444);
        chk("R5 no armed leftover", mode, 2'd0);

        // R6 suspend and resume
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0080);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(16'h0100, 16'h0030);
        wr(16'h0000, 16'h00B0);
        chk("R6 suspended mode", mode, 2'd3);
        chk("R6 suspended ready", rb_line, 1'b1);
        repeat (60) @(negedge clk);
        chk("R6 stays suspended", mode, 2'd3);
        wr(16'h0000, 16'h0030);
        chk("R6 resumed busy", rb_line, 1'b0);
        repeat (ERS_C - 4) @(negedge clk);
        chk("R6 resumed still busy", mode, 2'd2);
        @(negedge clk);
        chk("R6 total erase time kept", rb_line, 1'b1);

        // R9 lockout abandons erase and ignores writes
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0080);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0010);
        @(negedge clk); lockout = 1'b1;
        @(negedge clk);
        chk("R9 lockout read", mode, 2'd0);
        chk("R9 lockout ready", rb_line, 1'b1);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(16'h0005, 16'h5555);
        chk("R9 writes ignored", mode, 2'd0);
        lockout = 1'b0;
        // partial sequence then lockout pulse
        wr(KA, 16'h00AA); wr(KB, 16'h0055);
        @(negedge clk); lockout = 1'b1;
        @(negedge clk); lockout = 1'b0;
        wr(KA, 16'h00A0); wr(16'h0006, 16'h6666);
        chk("R9 partial sequence dropped", mode, 2'd0);

        // R10 abort during program
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(16'h0007, 16'h7777);
        @(negedge clk); abort_req = 1'b1;
        #1;
        chk("R10 line low during abort", rb_line, 1'b0);
        @(negedge clk);
        chk("R10 read mode", mode, 2'd0);
        wr(KA, 16'h00AA);
        abort_req = 1'b0;
        #1;
        chk("R10 line released", rb_line, 1'b1);
        wr(KB, 16'h0055);
        chk("R10 write during abort ignored", mode, 2'd0);
        wr(KA, 16'h00A0);
        chk("R10 no program armed", mode, 2'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule